// File: doc/BRIEF.md
# SPI Word-to-Byte Data Queue

This block sits between a 32-bit host register port and a byte-serial SPI shifter. On the transmit path the host writes 32-bit words, each carrying one to four valid bytes. The valid bytes are split out in a configurable byte order and placed in a 32-byte queue. The shifter drains that queue one byte at a time, and each byte is presented in the configured bit order. On the receive path the shifter hands in bytes one by one. They are bit-ordered, packed into 32-bit words in a configurable lane order, and queued eight words deep for the host to read.

Each direction has its own bit-order mode and its own byte-order mode, held in a small configuration register. The MSB-first modes come out of reset set and the big-endian modes come out of reset clear. A transfer of N bytes uses ceil(N/4) host words. On transmit, the unused lanes of the last word are dropped. On receive, the last word is closed early by a "last" marker and its empty lanes are filled with zeros. The block reports its fill levels and full/empty flags. It raises a sticky error on an overrun or an underrun. A software flush empties both paths.

Top module: `spi_wbyte_queue`

## Requirements
- R1: After reset both paths are empty, `tx_level` and `rx_level` are 0, `tx_empty` and `rx_empty` are 1, `fifo_err` is 0, both MSB-first modes are 1 and both big-endian modes are 0.
- R2: A host write with `tx_big_endian`=0 appends `host_wr_nbytes_m1`+1 bytes to the transmit queue. They are taken from the lowest lane upward, starting at bits [7:0], and the lanes above them are discarded.
- R3: With `tx_big_endian`=1, a host write appends its bytes from the highest lane downward, starting at bits [31:24], and the lanes below them are discarded.
- R4: The shifter sends bit 7 of `tx_byte` first. With the transmit MSB-first mode at 1, the queued byte is presented unchanged. With the mode at 0, it is presented bit-reversed, so the byte's bit 0 is sent first.
- R5: With receive big-endian at 0, the k-th received byte of a word (k = 0..3) lands in lane k (bits [8k+7:8k]). The word enters the receive queue in the cycle after its fourth byte arrives.
- R6: With receive big-endian at 1, the k-th received byte lands in lane 3-k.
- R7: `rx_byte` bit 7 holds the first bit received. With the receive MSB-first mode at 0, the byte is bit-reversed before it is packed.
- R8: A byte arriving with `rx_byte_last`=1 closes the current word. Its unfilled lanes are zero and the word enters the receive queue.
- R9: `tx_level` counts queued transmit bytes (at most 32), and `tx_full` is 1 while fewer than 4 bytes are free. `rx_level` counts queued receive words (at most 8), and `rx_full` is 1 at 8 words.
- R10: A host write needing more bytes than are free, or a host read while `rx_empty` is 1, leaves both queues unchanged and sets `fifo_err`. The flag then stays 1 until a flush.
- R11: A `soft_rst` pulse empties both queues, discards a partially packed receive word and clears `fifo_err`. It keeps the configuration.
- R12: A received word that completes while the receive queue holds 8 words is discarded and sets `fifo_err`. The queued words are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of both paths and of the error flag |
| cfg_we | input | 1 | Loads the four mode bits below |
| cfg_tx_msb_first | input | 1 | Transmit bit order (1: MSB first) |
| cfg_rx_msb_first | input | 1 | Receive bit order (1: MSB first) |
| cfg_tx_big_endian | input | 1 | Transmit byte order (1: top lane first) |
| cfg_rx_big_endian | input | 1 | Receive byte order (1: first byte in top lane) |
| host_wr_en | input | 1 | Host word write strobe |
| host_wr_data | input | 32 | Host write word |
| host_wr_nbytes_m1 | input | 2 | Valid bytes in the write word, minus one |
| host_rd_en | input | 1 | Host read strobe (pops the head word) |
| host_rd_data | output | 32 | Head word of the receive queue |
| tx_byte_valid | output | 1 | Transmit byte available |
| tx_byte | output | 8 | Transmit byte, bit 7 to be sent first |
| tx_byte_ready | input | 1 | Shifter takes the byte |
| rx_byte_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte, bit 7 received first |
| rx_byte_last | input | 1 | Received byte ends the transfer |
| tx_level | output | 6 | Queued transmit bytes |
| tx_full | output | 1 | Fewer than 4 transmit bytes free |
| tx_empty | output | 1 | Transmit queue empty |
| rx_level | output | 4 | Queued receive words |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| fifo_err | output | 1 | Sticky overrun/underrun flag |

## Verification
Writes, reads, pops, received bytes and flushes all take effect at the clock edge where they are sampled. Levels, flags, `fifo_err` and the queue heads therefore show the result one edge after the strobe. `tx_byte` and `host_rd_data` follow the queue head combinationally, including a change of bit-order mode. Every strobe is raised for exactly one cycle at a falling edge. Each result is read at the next falling edge, and a head value is captured just before the strobe that pops it, so every sample falls half a period away from the edge that produced it.

// File: rtl/spi_wbq_pkg.sv
package spi_wbq_pkg;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned LANES   = WORD_W / BYTE_W;

   typedef struct packed {
      logic tx_msb_first;
      logic rx_msb_first;
      logic tx_big_endian;
      logic rx_big_endian;
   } wbq_cfg_t;

   localparam wbq_cfg_t CFG_RESET = '{
      tx_msb_first:  1'b1,
      rx_msb_first:  1'b1,
      tx_big_endian: 1'b0,
      rx_big_endian: 1'b0
   };

   function automatic logic [BYTE_W-1:0] bit_rev(input logic [BYTE_W-1:0] b);
      logic [BYTE_W-1:0] r;
      for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
      return r;
   endfunction

   function automatic logic [BYTE_W-1:0] bit_order(input logic [BYTE_W-1:0] b,
                                                  input logic msb_first);
      return msb_first ? b : bit_rev(b);
   endfunction

endpackage

// File: rtl/wbq_tx_bytes.sv
module wbq_tx_bytes
   import spi_wbq_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [1:0]        wr_cnt_m1,
   input  logic              big_endian,
   input  logic              msb_first,
   input  logic              rd_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte,
   output logic [LW-1:0]     level,
   output logic              full,
   output logic              empty,
   output logic              reject
);

   if (DEPTH < LANES || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbq_tx_bytes: DEPTH must be a power of two of at least one word");
   end

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr, rptr;
   logic [LW-1:0]     cnt, free_b;
   logic [2:0]        wr_n;
   logic              accept, pop;
   logic [BYTE_W-1:0] lane_byte [LANES];

   // byte k of the write, in queue order, picked per byte-order mode
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_comb begin
         if (big_endian) lane_byte[k] = wr_word[BYTE_W*(LANES-1-k) +: BYTE_W];
         else            lane_byte[k] = wr_word[BYTE_W*k +: BYTE_W];
      end
   end

   assign wr_n   = {1'b0, wr_cnt_m1} + 3'd1;
   assign free_b = LW'(DEPTH) - cnt;
   assign accept = wr_en && !flush && (free_b >= LW'(wr_n));
   assign reject = wr_en && !flush && !accept;
   assign pop    = rd_ready && (cnt != '0) && !flush;

   always_ff @(posedge clk) begin
      if (accept) begin
         for (int k = 0; k < LANES; k++) begin
            if (3'(k) < wr_n) mem[wptr + AW'(k)] <= lane_byte[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (accept) wptr <= wptr + AW'(wr_n);
         if (pop)    rptr <= rptr + AW'(1);
         cnt <= cnt + (accept ? LW'(wr_n) : LW'(0)) - (pop ? LW'(1) : LW'(0));
      end
   end

   assign out_valid = (cnt != '0);
   assign out_byte  = bit_order(mem[rptr], msb_first);
   assign level     = cnt;
   assign full      = free_b < LW'(LANES);
   assign empty     = (cnt == '0);

   AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LW'(DEPTH)); // R9
   AST_TX_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reject && !rd_ready) |=> $stable(cnt)); // R10

endmodule

// File: rtl/wbq_rx_pack.sv
module wbq_rx_pack
   import spi_wbq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_last,
   input  logic              big_endian,
   input  logic              msb_first,
   output logic              out_push,
   output logic [WORD_W-1:0] out_word
);

   localparam int unsigned CW = $clog2(LANES);

   logic [WORD_W-1:0] acc, merged;
   logic [CW-1:0]     fill, lane;
   logic [BYTE_W-1:0] ordered;

   assign ordered = bit_order(in_byte, msb_first);
   assign lane    = big_endian ? CW'(LANES - 1) - fill : fill;

   always_comb begin
      merged = acc;
      merged[BYTE_W*lane +: BYTE_W] = ordered;
   end

   assign out_push = in_valid && !flush && (in_last || fill == CW'(LANES - 1));
   assign out_word = merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         fill <= '0;
      end else if (flush || out_push) begin
         acc  <= '0;
         fill <= '0;
      end else if (in_valid) begin
         acc  <= merged;
         fill <= fill + CW'(1);
      end
   end

   AST_PACK_FULLWORD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !flush && fill == CW'(LANES - 1)) |-> out_push); // R5

endmodule

// File: rtl/wbq_word_fifo.sv
module wbq_word_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [LW-1:0]    level,
   output logic             full,
   output logic             empty,
   output logic             overflow,
   output logic             underflow
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbq_word_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [LW-1:0]    cnt;
   logic             do_push, do_pop;

   assign full      = (cnt == LW'(DEPTH));
   assign empty     = (cnt == '0);
   assign overflow  = push && full && !flush;
   assign underflow = pop && empty && !flush;
   assign do_push   = push && !full && !flush;
   assign do_pop    = pop && !empty && !flush;

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + AW'(1);
         if (do_pop)  rptr <= rptr + AW'(1);
         cnt <= cnt + (do_push ? LW'(1) : LW'(0)) - (do_pop ? LW'(1) : LW'(0));
      end
   end

   assign dout  = mem[rptr];
   assign level = cnt;

   AST_WF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !pop) |=> full); // R12
   AST_WF_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !push) |=> (cnt <= $past(cnt))); // R9

endmodule

// File: rtl/spi_wbyte_queue.sv
module spi_wbyte_queue
   import spi_wbq_pkg::*;
#(
   parameter int unsigned TX_BYTES = 32,
   parameter int unsigned RX_WORDS = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            soft_rst,
   input  logic                            cfg_we,
   input  logic                            cfg_tx_msb_first,
   input  logic                            cfg_rx_msb_first,
   input  logic                            cfg_tx_big_endian,
   input  logic                            cfg_rx_big_endian,
   input  logic                            host_wr_en,
   input  logic [31:0]                     host_wr_data,
   input  logic [1:0]                      host_wr_nbytes_m1,
   input  logic                            host_rd_en,
   output logic [31:0]                     host_rd_data,
   output logic                            tx_byte_valid,
   output logic [7:0]                      tx_byte,
   input  logic                            tx_byte_ready,
   input  logic                            rx_byte_valid,
   input  logic [7:0]                      rx_byte,
   input  logic                            rx_byte_last,
   output logic [$clog2(TX_BYTES+1)-1:0]   tx_level,
   output logic                            tx_full,
   output logic                            tx_empty,
   output logic [$clog2(RX_WORDS+1)-1:0]   rx_level,
   output logic                            rx_full,
   output logic                            rx_empty,
   output logic                            fifo_err
);

   wbq_cfg_t          cfg_q;
   logic              err_q, tx_reject, rx_ovf, rx_udf;
   logic              pk_push;
   logic [WORD_W-1:0] pk_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= CFG_RESET;
      else if (cfg_we) cfg_q <= '{tx_msb_first:  cfg_tx_msb_first,
                                  rx_msb_first:  cfg_rx_msb_first,
                                  tx_big_endian: cfg_tx_big_endian,
                                  rx_big_endian: cfg_rx_big_endian};
   end

   wbq_tx_bytes #(.DEPTH(TX_BYTES)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (soft_rst),
      .wr_en      (host_wr_en),
      .wr_word    (host_wr_data),
      .wr_cnt_m1  (host_wr_nbytes_m1),
      .big_endian (cfg_q.tx_big_endian),
      .msb_first  (cfg_q.tx_msb_first),
      .rd_ready   (tx_byte_ready),
      .out_valid  (tx_byte_valid),
      .out_byte   (tx_byte),
      .level      (tx_level),
      .full       (tx_full),
      .empty      (tx_empty),
      .reject     (tx_reject)
   );

   wbq_rx_pack u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (soft_rst),
      .in_valid   (rx_byte_valid),
      .in_byte    (rx_byte),
      .in_last    (rx_byte_last),
      .big_endian (cfg_q.rx_big_endian),
      .msb_first  (cfg_q.rx_msb_first),
      .out_push   (pk_push),
      .out_word   (pk_word)
   );

   wbq_word_fifo #(.WIDTH(WORD_W), .DEPTH(RX_WORDS)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (soft_rst),
      .push      (pk_push),
      .din       (pk_word),
      .pop       (host_rd_en),
      .dout      (host_rd_data),
      .level     (rx_level),
      .full      (rx_full),
      .empty     (rx_empty),
      .overflow  (rx_ovf),
      .underflow (rx_udf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_q <= 1'b0;
      else if (soft_rst) err_q <= 1'b0;
      else if (tx_reject || rx_ovf || rx_udf) err_q <= 1'b1;
   end

   assign fifo_err = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !soft_rst) |=> err_q); // R10
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (tx_empty && rx_empty && !fifo_err)); // R11
   AST_UNDERRUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && rx_empty && !soft_rst) |=> fifo_err); // R10

endmodule

// File: tb/spi_wbyte_queue_tb.sv
module spi_wbyte_queue_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0, cfg_we = 1'b0;
   logic        c_txm = 1'b1, c_rxm = 1'b1, c_txb = 1'b0, c_rxb = 1'b0;
   logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
   logic [31:0] host_wr_data = '0, host_rd_data;
   logic [1:0]  host_wr_nbytes_m1 = '0;
   logic        tx_byte_valid, tx_byte_ready = 1'b0;
   logic [7:0]  tx_byte, rx_byte = '0;
   logic        rx_byte_valid = 1'b0, rx_byte_last = 1'b0;
   logic [5:0]  tx_level;
   logic [3:0]  rx_level;
   logic        tx_full, tx_empty, rx_full, rx_empty, fifo_err;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_wbyte_queue u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
      .cfg_tx_msb_first(c_txm), .cfg_rx_msb_first(c_rxm),
      .cfg_tx_big_endian(c_txb), .cfg_rx_big_endian(c_rxb),
      .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .host_wr_nbytes_m1(host_wr_nbytes_m1), .host_rd_en(host_rd_en),
      .host_rd_data(host_rd_data), .tx_byte_valid(tx_byte_valid),
      .tx_byte(tx_byte), .tx_byte_ready(tx_byte_ready),
      .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_byte_last(rx_byte_last),
      .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty),
      .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty),
      .fifo_err(fifo_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_cfg(input logic txm, rxm, txb, rxb);
      @(negedge clk);
      c_txm = txm; c_rxm = rxm; c_txb = txb; c_rxb = rxb; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic flush();
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
   endtask

   task automatic hwrite(input logic [31:0] w, input logic [1:0] nm1);
      @(negedge clk);
      host_wr_data = w; host_wr_nbytes_m1 = nm1; host_wr_en = 1'b1;
      @(negedge clk);
      host_wr_en = 1'b0;
   endtask

   task automatic tpop(output logic [7:0] b);
      @(negedge clk);
      b = tx_byte; tx_byte_ready = 1'b1;
      @(negedge clk);
      tx_byte_ready = 1'b0;
   endtask

   task automatic rpush(input logic [7:0] b, input logic last);
      @(negedge clk);
      rx_byte = b; rx_byte_last = last; rx_byte_valid = 1'b1;
      @(negedge clk);
      rx_byte_valid = 1'b0; rx_byte_last = 1'b0;
   endtask

   task automatic hread(output logic [31:0] w);
      @(negedge clk);
      w = host_rd_data; host_rd_en = 1'b1;
      @(negedge clk);
      host_rd_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] b;
      @(negedge clk);
      chk("R1 tx_level", tx_level, 0);
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 rx_level", rx_level, 0);
      chk("R1 rx_empty", rx_empty, 1);
      chk("R1 fifo_err", fifo_err, 0);
      hwrite(32'h8040_2001, 2'd3);
      tpop(b); chk("R1 default order byte0", b, 8'h01);
      tpop(b); chk("R1 default order byte1", b, 8'h20);
      flush();
   endtask

   task automatic t_tx_little();
      logic [7:0] b;
      set_cfg(1, 1, 0, 0);
      hwrite(32'hAABB_CCDD, 2'd1);
      chk("R2 level after 2-byte write", tx_level, 2);
      tpop(b); chk("R2 first lane", b, 8'hDD);
      tpop(b); chk("R2 second lane", b, 8'hCC);
      chk("R2 unused lanes dropped", tx_empty, 1);
   endtask

   task automatic t_tx_big();
      logic [7:0] b;
      set_cfg(1, 1, 1, 0);
      hwrite(32'h1122_3344, 2'd2);
      chk("R3 level", tx_level, 3);
      tpop(b); chk("R3 byte0", b, 8'h11);
      tpop(b); chk("R3 byte1", b, 8'h22);
      tpop(b); chk("R3 byte2", b, 8'h33);
      chk("R3 bottom lane dropped", tx_empty, 1);
   endtask

   task automatic t_tx_bitorder();
      logic [7:0] b;
      set_cfg(0, 1, 0, 0);
      hwrite(32'h0000_0301, 2'd1);
      tpop(b); chk("R4 lsb-first 01", b, 8'h80);
      tpop(b); chk("R4 lsb-first 03", b, 8'hC0);
      set_cfg(1, 1, 0, 0);
      hwrite(32'h0000_00A1, 2'd0);
      tpop(b); chk("R4 msb-first unchanged", b, 8'hA1);
   endtask

   task automatic t_rx_little();
      logic [31:0] w;
      set_cfg(1, 1, 0, 0);
      rpush(8'h01, 0); rpush(8'h02, 0); rpush(8'h03, 0);
      chk("R5 no word before 4th byte", rx_level, 0);
      rpush(8'h04, 0);
      chk("R5 word queued", rx_level, 1);
      hread(w); chk("R5 little packing", w, 32'h0403_0201);
   endtask

   task automatic t_rx_big();
      logic [31:0] w;
      set_cfg(1, 1, 0, 1);
      rpush(8'h01, 0); rpush(8'h02, 0); rpush(8'h03, 0); rpush(8'h04, 0);
      hread(w); chk("R6 big packing", w, 32'h0102_0304);
   endtask

   task automatic t_rx_pad();
      logic [31:0] w;
      set_cfg(1, 0, 0, 0);
      rpush(8'h01, 1);
      chk("R8 last closes word", rx_level, 1);
      hread(w); chk("R7 R8 lsb-first padded", w, 32'h0000_0080);
      set_cfg(1, 1, 0, 1);
      rpush(8'hAA, 0); rpush(8'hBB, 1);
      hread(w); chk("R8 big padded", w, 32'hAABB_0000);
   endtask

   task automatic t_tx_levels();
      logic [7:0] b;
      set_cfg(1, 1, 0, 0);
      for (int i = 0; i < 7; i++) hwrite({4{8'(i + 1)}}, 2'd3);
      chk("R9 level 28", tx_level, 28);
      chk("R9 not full at 4 free", tx_full, 0);
      hwrite(32'h0807_0605, 2'd3);
      chk("R9 level 32", tx_level, 32);
      chk("R9 full", tx_full, 1);
      hwrite(32'hDEAD_BEEF, 2'd0);
      chk("R10 reject level", tx_level, 32);
      chk("R10 reject sets err", fifo_err, 1);
      for (int i = 0; i < 32; i++) tpop(b);
      chk("R10 contents kept last byte", b, 8'h08);
      chk("R9 empty after drain", tx_empty, 1);
      chk("R10 err sticky", fifo_err, 1);
      flush();
      chk("R11 err cleared", fifo_err, 0);
   endtask

   task automatic t_rx_underflow();
      logic [31:0] w;
      hread(w);
      chk("R10 read-empty err", fifo_err, 1);
      chk("R10 read-empty level", rx_level, 0);
      flush();
   endtask

   task automatic t_rx_overflow();
      logic [31:0] w;
      set_cfg(1, 1, 0, 0);
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 4; j++) rpush(8'(16 * i + j), 0);
      chk("R9 rx_level 8", rx_level, 8);
      chk("R9 rx_full", rx_full, 1);
      chk("R12 no err yet", fifo_err, 0);
      for (int j = 0; j < 4; j++) rpush(8'hEE, 0);
      chk("R12 overflow err", fifo_err, 1);
      chk("R12 level kept", rx_level, 8);
      hread(w); chk("R12 head kept", w, 32'h0302_0100);
      flush();
   endtask

   task automatic t_soft_reset();
      logic [31:0] w;
      logic [7:0]  b;
      set_cfg(0, 1, 0, 0);
      rpush(8'h55, 0); rpush(8'h66, 0);
      hwrite(32'h1234_5678, 2'd3);
      flush();
      chk("R11 tx flushed", tx_level, 0);
      chk("R11 rx flushed", rx_empty, 1);
      rpush(8'h11, 0); rpush(8'h22, 0); rpush(8'h33, 0); rpush(8'h44, 0);
      hread(w); chk("R11 partial discarded", w, 32'h4433_2211);
      hwrite(32'h0000_0001, 2'd0);
      tpop(b); chk("R11 cfg kept lsb-first", b, 8'h80);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_tx_little();
      t_tx_big();
      t_tx_bitorder();
      t_rx_little();
      t_rx_big();
      t_rx_pad();
      t_tx_levels();
      t_rx_underflow();
      t_rx_overflow();
      t_soft_reset();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule